// File: doc/BRIEF.md
# Serial GPIO Shift Controller

This block stretches a four-wire serial link into up to 32 bidirectional general-purpose slots. An external chain of shift registers sits on the far end of the link. Every slot carries one output bit, taken from an output latch, and one input bit, which is sampled back into an input register. Both bits move in the same frame.

Software uses a small register bus. A control word enables the engine, sets how many slots are active (in groups of eight) and sets the serial clock divider. Writing the value register loads the output latch. Reading the same address returns the sampled inputs, so changing a single output is a read-modify-write that goes through the separate readback register, which returns the latch.

While the engine is enabled it runs frames back to back. Each frame opens with a load strobe that lasts one serial clock period. After the strobe comes one serial clock period per active slot, with slot 0 first. Output bits change on the falling serial clock edge and input bits are captured on the rising edge.

Top module: `sgpio_chain_ctrl`

## Requirements
- R1: After reset the control word, the value register and the readback register all read 0, the serial clock is high and the load strobe is low.
- R2: The control word sits at bus address 0. Bit 0 enables the engine. Bits 6 and up, CNT_W bits wide (4, or 5 in the wide variant), give the slot count in groups of eight. Bits 31:16 give the divider D. A read returns the written fields and 0 in every other bit. Reads return data on the clock after the request.
- R3: While the engine is enabled, each half of the serial clock lasts D+1 system clocks, so the full period is 2*(D+1).
- R4: A frame starts with the load strobe high for exactly one serial clock period, with the serial clock low in the first half of that period. One serial clock period per active slot follows.
- R5: The output bit for slot k is driven on the falling serial clock edge that opens slot k's period, with slot 0 first. The data line does not change while the serial clock is high.
- R6: The input bit for slot k is sampled on the rising serial clock edge of slot k's period. The value register (address 1) updates only when a frame completes, with bit k holding slot k.
- R7: The number of active slots is 8 times the count field, capped at NUM_SLOTS. Value register bits for slots at or above the active count read 0.
- R8: A write to address 1 loads the output latch. Address 2 reads back the latch. A read of address 1 never returns the latch.
- R9: One clock after the enable bit is cleared, the serial clock is high and the load strobe is low. The value register then holds its contents. Setting the enable bit again starts a fresh frame.
- R10: A new divider or slot count written during a frame takes effect only at the next frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address (0 control, 1 value, 2 readback) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after a read |
| ser_clk | output | 1 | Serial clock, idles high |
| ser_load | output | 1 | Frame load strobe |
| ser_dout | output | 1 | Serial output data |
| ser_din | input | 1 | Serial input data |

## Verification
The hardest case to reach is a configuration change that lands in the middle of a running frame. The old divider and slot count must finish that frame, and the new ones must take over exactly at the next load strobe. The bench reaches this case by waiting for a strobe to rise, then writing a new divider and count a few clocks later. A loopback expander model tracks the length of each frame, and a per-clock timing monitor switches its expected half-period only when it sees the strobe rise. Disabling the engine mid-frame and then resuming is a second hard case, because the partial frame must not reach the value register.

// File: rtl/sgpio_pkg.sv
package sgpio_pkg;
  localparam int EN_BIT  = 0;
  localparam int CNT_LSB = 6;
  localparam int DIV_LSB = 16;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_VALUE = 2'd1,
    REG_RDBK  = 2'd2
  } sgpio_reg_e;
endpackage

// File: rtl/sgpio_regs.sv
module sgpio_regs
  import sgpio_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_SLOTS = 32,
  parameter int CNT_W     = 4,
  parameter int DIV_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [1:0]           bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 ctl_en,
  output logic [CNT_W-1:0]     ctl_cnt,
  output logic [DIV_W-1:0]     ctl_div,
  output logic [NUM_SLOTS-1:0] out_latch,
  input  logic [NUM_SLOTS-1:0] in_value
);
  logic [DATA_W-1:0] ctl_word;
  logic              wr_val;
  logic              unused_wbits;

  assign unused_wbits = ^bus_wdata;
  assign wr_val = bus_sel && bus_wr && (bus_addr == REG_VALUE);

  always_comb begin
    ctl_word = '0;
    ctl_word[EN_BIT] = ctl_en;
    ctl_word[CNT_LSB +: CNT_W] = ctl_cnt;
    ctl_word[DIV_LSB +: DIV_W] = ctl_div;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en    <= 1'b0;
      ctl_cnt   <= '0;
      ctl_div   <= '0;
      out_latch <= '0;
      bus_rdata <= '0;
    end else if (bus_sel) begin
      if (bus_wr) begin
        case (bus_addr)
          REG_CTRL: begin
            ctl_en  <= bus_wdata[EN_BIT];
            ctl_cnt <= bus_wdata[CNT_LSB +: CNT_W];
            ctl_div <= bus_wdata[DIV_LSB +: DIV_W];
          end
          REG_VALUE: out_latch <= bus_wdata[NUM_SLOTS-1:0];
          default: ;
        endcase
      end else begin
        case (bus_addr)
          REG_CTRL:  bus_rdata <= ctl_word;
          REG_VALUE: bus_rdata <= DATA_W'(in_value);
          REG_RDBK:  bus_rdata <= DATA_W'(out_latch);
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end

  // R8
  latch_write_only_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_val |=> $stable(out_latch));
endmodule

// File: rtl/sgpio_tick.sv
module sgpio_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)    cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = !clear && (cnt == div);

  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    !clear |-> cnt <= div);
endmodule

// File: rtl/sgpio_engine.sv
module sgpio_engine #(
  parameter int NUM_SLOTS = 32,
  parameter int CNT_W     = 4,
  parameter int DIV_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [CNT_W-1:0]     cnt_field,
  input  logic [DIV_W-1:0]     div,
  input  logic [NUM_SLOTS-1:0] out_latch,
  input  logic                 ser_din,
  input  logic                 tick,
  output logic                 run,
  output logic [DIV_W-1:0]     div_q,
  output logic                 ser_clk,
  output logic                 ser_load,
  output logic                 ser_dout,
  output logic [NUM_SLOTS-1:0] in_value
);
  localparam int SLOT_W = $clog2(NUM_SLOTS + 1);
  localparam int IDX_W  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int RAW_W  = CNT_W + 3;

  logic [SLOT_W-1:0]    idx;
  logic [SLOT_W-1:0]    nsl_q;
  logic                 half;
  logic [NUM_SLOTS-1:0] out_sh;
  logic [NUM_SLOTS-1:0] in_sh;
  logic [IDX_W-1:0]     wr_pos;
  logic [IDX_W-1:0]     rd_pos;

  function automatic logic [SLOT_W-1:0] slots_of(input logic [CNT_W-1:0] f);
    logic [RAW_W-1:0] raw;
    raw = {f, 3'b000};
    if (int'(raw) > NUM_SLOTS) return SLOT_W'(NUM_SLOTS);
    return SLOT_W'(raw);
  endfunction

  function automatic logic [NUM_SLOTS-1:0] mask_of(input logic [SLOT_W-1:0] n);
    logic [NUM_SLOTS-1:0] m;
    for (int i = 0; i < NUM_SLOTS; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  assign wr_pos = IDX_W'(idx - 1'b1);
  assign rd_pos = IDX_W'(idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      idx      <= '0;
      nsl_q    <= '0;
      half     <= 1'b0;
      div_q    <= '0;
      ser_clk  <= 1'b1;
      ser_load <= 1'b0;
      ser_dout <= 1'b0;
      out_sh   <= '0;
      in_sh    <= '0;
      in_value <= '0;
    end else if (!en) begin
      run      <= 1'b0;
      ser_clk  <= 1'b1;
      ser_load <= 1'b0;
    end else if (!run || (tick && half && (idx == nsl_q))) begin
      if (run) in_value <= in_sh & mask_of(nsl_q);
      run      <= 1'b1;
      idx      <= '0;
      half     <= 1'b0;
      nsl_q    <= slots_of(cnt_field);
      div_q    <= div;
      out_sh   <= out_latch;
      ser_clk  <= 1'b0;
      ser_load <= 1'b1;
      ser_dout <= 1'b0;
    end else if (tick) begin
      if (!half) begin
        half    <= 1'b1;
        ser_clk <= 1'b1;
        if (idx != '0) in_sh[wr_pos] <= ser_din;
      end else begin
        half     <= 1'b0;
        idx      <= idx + 1'b1;
        ser_clk  <= 1'b0;
        ser_load <= 1'b0;
        ser_dout <= out_sh[rd_pos];
      end
    end
  end

  // R9
  idle_state_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (ser_clk && !ser_load));

  // R4
  load_starts_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_load) |-> !ser_clk);

  // R5
  dout_stable_high_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_dout));

  // R6
  value_on_frame_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(ser_load) |-> $stable(in_value));
endmodule

// File: rtl/sgpio_chain_ctrl.sv
module sgpio_chain_ctrl #(
  parameter int NUM_SLOTS  = 32,
  parameter bit WIDE_COUNT = 1'b0,
  parameter int DIV_W      = 16,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ser_clk,
  output logic              ser_load,
  output logic              ser_dout,
  input  logic              ser_din
);
  localparam int CNT_W = WIDE_COUNT ? 5 : 4;

  logic                 ctl_en;
  logic [CNT_W-1:0]     ctl_cnt;
  logic [DIV_W-1:0]     ctl_div;
  logic [DIV_W-1:0]     div_q;
  logic [NUM_SLOTS-1:0] out_latch;
  logic [NUM_SLOTS-1:0] in_value;
  logic                 run;
  logic                 tick;

  sgpio_regs #(
    .DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W), .DIV_W(DIV_W)
  ) regs_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ctl_en(ctl_en), .ctl_cnt(ctl_cnt), .ctl_div(ctl_div),
    .out_latch(out_latch), .in_value(in_value)
  );

  sgpio_tick #(.DIV_W(DIV_W)) tick_i (
    .clk(clk), .rst(rst), .clear(!run || !ctl_en), .div(div_q), .tick(tick)
  );

  sgpio_engine #(
    .NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W), .DIV_W(DIV_W)
  ) engine_i (
    .clk(clk), .rst(rst), .en(ctl_en), .cnt_field(ctl_cnt), .div(ctl_div),
    .out_latch(out_latch), .ser_din(ser_din), .tick(tick), .run(run),
    .div_q(div_q), .ser_clk(ser_clk), .ser_load(ser_load),
    .ser_dout(ser_dout), .in_value(in_value)
  );
endmodule

// File: tb/sgpio_chain_ctrl_tb_top.sv
module sgpio_chain_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ser_clk, ser_load, ser_dout;
  logic        ser_din;

  int checks = 0;
  int errors = 0;

  logic [31:0] in_pat = '0;
  logic [31:0] rcv = '0;
  logic [31:0] last_rcv = '0;
  int ptr = -1;
  int last_ptr = -1;
  int frames = 0;
  logic prev_clk = 1'b1;
  logic prev_load = 1'b0;
  int hp_cnt = 0;
  int ld_cnt = 0;
  bit tmg_on = 1'b0;
  bit tmg_seen = 1'b0;
  int div_cur = 0;
  int div_next = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgpio_chain_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_clk(ser_clk), .ser_load(ser_load), .ser_dout(ser_dout),
    .ser_din(ser_din)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expander loopback model and per-clock timing reference
  always @(negedge clk) begin
    if (rst) begin
      ser_din <= 1'b0;
    end else begin
      hp_cnt++;
      if (ser_clk !== prev_clk) begin
        if (tmg_on && tmg_seen) check("R3 half period", hp_cnt, div_cur + 1);
        tmg_seen = tmg_on;
        hp_cnt = 0;
        if (!ser_clk && !ser_load) ptr++;
        if (ser_clk && !ser_load && ptr >= 0 && ptr < NS) rcv[ptr] = ser_dout;
      end
      if (ser_load && !prev_load) ld_cnt = 0;
      if (ser_load) ld_cnt++;
      else if (prev_load && tmg_on) check("R4 load width", ld_cnt, 2 * (div_cur + 1));
      if (ser_load && !prev_load) begin
        frames++;
        last_rcv = rcv;
        last_ptr = ptr;
        ptr = -1;
        rcv = '0;
        div_cur = div_next;   // R10 new divider only from this frame on
      end
      ser_din <= (ptr >= 0 && ptr < NS) ? in_pat[ptr] : 1'b0;
      prev_clk = ser_clk;
      prev_load = ser_load;
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_frames(input int n);
    int f0;
    f0 = frames;
    while (frames < f0 + n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] outp;
    logic [31:0] v0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 ser_clk", ser_clk, 1);
    check("R1 ser_load", ser_load, 0);
    bus_read(2'd0, d); check("R1 ctrl", d, 0);
    bus_read(2'd1, d); check("R1 value", d, 0);
    bus_read(2'd2, d); check("R1 readback", d, 0);

    // R2 control fields, junk bits dropped
    bus_write(2'd0, (32'd1 << 16) | (32'd4 << 6) | 32'h0000_1026);
    bus_read(2'd0, d); check("R2 ctrl readback", d, 32'h0001_0100);
    check("R9 idle clk while disabled", ser_clk, 1);

    // R8 latch write and readback
    outp = 32'hA5C3_0F96;
    bus_write(2'd1, outp);
    bus_read(2'd2, d); check("R8 readback", d, outp);
    bus_read(2'd1, d); check("R8 value not latch", d, 0);

    // R3 R4 R5 R6 full 32-slot frames, D=1
    in_pat = 32'h3C69_D2E1;
    div_next = 1; div_cur = 1; tmg_seen = 1'b0; tmg_on = 1'b1;
    bus_write(2'd0, 32'h0001_0101);
    wait_frames(3);
    bus_read(2'd1, d); check("R6 sampled inputs", d, in_pat);
    check("R5 shifted outputs", last_rcv, outp);
    check("R4 slots per frame", last_ptr, 31);

    // R7 cap at NUM_SLOTS
    bus_write(2'd0, 32'h0001_0141);
    wait_frames(3);
    check("R7 capped slot count", last_ptr, 31);

    // R7 eight slots, upper value bits read 0
    in_pat = 32'hF0F0_5A3C;
    bus_write(2'd0, 32'h0001_0041);
    wait_frames(3);
    check("R7 eight slots", last_ptr, 7);
    bus_read(2'd1, d); check("R7 masked value", d, in_pat & 32'hFF);
    check("R5 eight outputs", last_rcv, outp & 32'hFF);

    // R10 mid-frame change of divider and count
    wait_frames(1);
    repeat (3) @(negedge clk);
    div_next = 3;
    bus_write(2'd0, 32'h0003_0081);
    wait_frames(1);
    check("R10 old count kept", last_ptr, 7);
    wait_frames(1);
    check("R10 new count applied", last_ptr, 15);

    // R8 latch update while running
    outp = 32'h0000_6B1D;
    bus_write(2'd1, outp);
    wait_frames(3);
    check("R8 new outputs shifted", last_rcv, outp);
    bus_read(2'd2, d); check("R8 readback running", d, outp);
    bus_read(2'd1, d); check("R6 value 16 slots", d, in_pat & 32'hFFFF);

    // R9 disable mid-frame
    repeat (20) @(negedge clk);
    tmg_on = 1'b0;
    bus_read(2'd1, v0);
    bus_write(2'd0, 32'h0003_0080);
    in_pat = 32'h1234_9E47;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      check("R9 clk high", ser_clk, 1);
      check("R9 load low", ser_load, 0);
      repeat (25) @(negedge clk);
    end
    bus_read(2'd1, d); check("R9 value held", d, v0);

    // R9 resume starts a fresh frame
    tmg_seen = 1'b0; tmg_on = 1'b1;
    bus_write(2'd0, 32'h0003_0081);
    wait_frames(3);
    bus_read(2'd1, d); check("R9 resume value", d, in_pat & 32'hFFFF);
    check("R9 resume outputs", last_rcv, outp);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule